// File: doc/BRIEF.md
# Wakeup and External Interrupt Controller

This block collects a set of external pad inputs plus one non-maskable input and turns them into grouped interrupt requests and a single wakeup request for the power-mode logic. Each pad is first brought into the clock domain by a two-flop synchronizer. A transition on the synchronized sample becomes an event when the enable for that direction is set. An event sets a sticky per-source status flag, which stays set until software clears it by writing a one to its bit.

The status flags are masked by a per-source interrupt enable and ORed into three vector outputs. Each vector serves a fixed, consecutive range of sources. A separate per-source wakeup enable masks the same flags into the wakeup output. The non-maskable input has an event flag and an overrun flag. Its request stays raised while either flag is set.

A small register port with combinational reads gives software access to all enables and flags. A glitch-filter enable register is kept for software, but it has no digital effect inside the block.

Top module: `wkup_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_vec_o`, `wake_o` and `nmi_req_o` are low.
- R2: Register map by `reg_addr_i`: 0 = non-maskable status (bit 0 event flag, bit 1 overrun flag), 1 = source status flags, 2 = interrupt enables, 3 = wakeup enables, 4 = rising-edge enables, 5 = falling-edge enables, 6 = glitch-filter enables. Bit n of registers 1 to 6 belongs to source n. A rising (falling) pad transition sets status bit n only when bit n of register 4 (5) is set. The flag becomes readable after the third rising clock edge that follows the pad change.
- R3: A pad transition whose direction is not enabled leaves the status flag clear. An already-set flag is left unchanged by such a transition.
- R4: Writing to register 1 clears exactly the status bits written as 1. Writing 0 changes no flag.
- R5: If an edge event and a write-1 clear reach the same source flag in the same cycle, the flag stays set.
- R6: `irq_vec_o[0]` is the OR of sources 0–7, `irq_vec_o[1]` of sources 8–15 and `irq_vec_o[2]` of sources 16–19. Each source counts only when both its status flag and its interrupt enable are set.
- R7: `wake_o` is high exactly when some source has both its status flag and its wakeup enable set.
- R8: A rising transition on the synchronized non-maskable input sets the event flag and raises `nmi_req_o`.
- R9: A non-maskable event that arrives while the event flag is still set also sets the overrun flag.
- R10: The non-maskable flags clear only by writing 1 to their bits in register 0. `nmi_req_o` stays high while the overrun flag is set, even after the event flag has been cleared.
- R11: Register 6 reads back what was written to it. Its contents change neither edge detection nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | 20 | External pad inputs, asynchronous |
| nmi_pad_i | input | 1 | Non-maskable pad input, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_vec_o | output | 3 | Grouped interrupt vector requests |
| wake_o | output | 1 | Wakeup request toward power control |
| nmi_req_o | output | 1 | Non-maskable request |

## Verification
The hardest case to reach from the ports is an edge event and a software clear hitting the same flag in the same cycle. The event only lands at the clock edge that ends the synchronizer and edge-detector pipeline. The bench therefore first sets the flag. It then drives the opposite pad transition on a falling clock edge and raises the clear write exactly two falling edges later, so that both act at the third rising edge. The non-maskable overrun path is reached by toggling that input twice without clearing. The event flag is then cleared on its own to show that the request is still held.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   localparam int REG_ADDR_W = 3;
   localparam int REG_DATA_W = 32;

   typedef enum logic [REG_ADDR_W-1:0] {
      SEL_NMI_STAT  = 3'd0,
      SEL_SRC_STAT  = 3'd1,
      SEL_IRQ_EN    = 3'd2,
      SEL_WAKE_EN   = 3'd3,
      SEL_RISE_EN   = 3'd4,
      SEL_FALL_EN   = 3'd5,
      SEL_FILT_EN   = 3'd6,
      SEL_UNUSED    = 3'd7
   } reg_sel_e;

   localparam int NMI_EVT_BIT = 0;
   localparam int NMI_OVR_BIT = 1;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wkup_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wkup_src_flags.sv
module wkup_src_flags #(
   parameter int NUM_SRC = 20
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] smp_i,
   input  logic [NUM_SRC-1:0] rise_en_i,
   input  logic [NUM_SRC-1:0] fall_en_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] flag_o
);
   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] changed;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic rise_hit;
      logic fall_hit;

      assign changed[i] = smp_i[i] ^ prev_q[i];
      assign rise_hit   =  smp_i[i] & ~prev_q[i] & rise_en_i[i];
      assign fall_hit   = ~smp_i[i] &  prev_q[i] & fall_en_i[i];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prev_q[i] <= 1'b0;
            flag_q[i] <= 1'b0;
         end else begin
            prev_q[i] <= smp_i[i];
            // a new event wins over a simultaneous clear
            if (rise_hit || fall_hit) begin
               flag_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
               flag_q[i] <= 1'b0;
            end
         end
      end
   end

   assign flag_o = flag_q;

   // R4
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(flag_q & ~clr_i) & ~flag_q) == '0);
   // R3
   flag_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q & ~$past(flag_q) & ~$past(changed)) == '0);
endmodule

// File: rtl/wkup_nmi_unit.sv
module wkup_nmi_unit (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic smp_i,
   input  logic clr_evt_i,
   input  logic clr_ovr_i,
   output logic evt_o,
   output logic ovr_o,
   output logic req_o
);
   logic prev_q;
   logic evt_q;
   logic ovr_q;
   logic hit;

   assign hit = smp_i & ~prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         evt_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         prev_q <= smp_i;
         if (hit) begin
            evt_q <= 1'b1;
         end else if (clr_evt_i) begin
            evt_q <= 1'b0;
         end
         if (hit && evt_q) begin
            ovr_q <= 1'b1;
         end else if (clr_ovr_i) begin
            ovr_q <= 1'b0;
         end
      end
   end

   assign evt_o = evt_q;
   assign ovr_o = ovr_q;
   assign req_o = evt_q | ovr_q;

   // R9
   ovr_after_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovr_q) |-> $past(evt_q));
   // R10
   ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ovr_q) && !$past(clr_ovr_i)) |-> ovr_q);
endmodule

// File: rtl/wkup_vec_merge.sv
module wkup_vec_merge #(
   parameter int NUM_SRC  = 20,
   parameter int GRP_SIZE = 8,
   parameter int NUM_VEC  = (NUM_SRC + GRP_SIZE - 1) / GRP_SIZE
) (
   input  logic [NUM_SRC-1:0] flag_i,
   input  logic [NUM_SRC-1:0] irq_en_i,
   input  logic [NUM_SRC-1:0] wake_en_i,
   output logic [NUM_VEC-1:0] vec_o,
   output logic               wake_o
);
   logic [NUM_SRC-1:0] irq_live;

   assign irq_live = flag_i & irq_en_i;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      localparam int LO = v * GRP_SIZE;
      localparam int HI = ((v + 1) * GRP_SIZE > NUM_SRC) ? NUM_SRC - 1
                                                         : (v + 1) * GRP_SIZE - 1;
      assign vec_o[v] = |irq_live[HI:LO];
   end

   assign wake_o = |(flag_i & wake_en_i);
endmodule

// File: rtl/wkup_irq_ctrl.sv
module wkup_irq_ctrl
   import wkup_pkg::*;
#(
   parameter int NUM_SRC     = 20,
   parameter int GRP_SIZE    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_VEC     = (NUM_SRC + GRP_SIZE - 1) / GRP_SIZE
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_SRC-1:0]    pad_i,
   input  logic                  nmi_pad_i,
   input  logic                  reg_we_i,
   input  logic [REG_ADDR_W-1:0] reg_addr_i,
   input  logic [REG_DATA_W-1:0] reg_wdata_i,
   output logic [REG_DATA_W-1:0] reg_rdata_o,
   output logic [NUM_VEC-1:0]    irq_vec_o,
   output logic                  wake_o,
   output logic                  nmi_req_o
);
   localparam int SYNC_W = NUM_SRC + 1;

   if (NUM_SRC < 1 || NUM_SRC > REG_DATA_W) begin : g_bad_src
      $error("wkup_irq_ctrl: NUM_SRC must lie in 1..REG_DATA_W");
   end
   if (GRP_SIZE < 1) begin : g_bad_grp
      $error("wkup_irq_ctrl: GRP_SIZE must be positive");
   end
   if (NUM_VEC != (NUM_SRC + GRP_SIZE - 1) / GRP_SIZE) begin : g_bad_vec
      $error("wkup_irq_ctrl: NUM_VEC does not match NUM_SRC and GRP_SIZE");
   end

   logic [NUM_SRC-1:0] irq_en_q, wake_en_q, rise_en_q, fall_en_q, filt_en_q;
   logic [NUM_SRC-1:0] src_flag, src_clr;
   logic [SYNC_W-1:0]  sync_all;
   logic               nmi_evt, nmi_ovr;
   logic               wr_src, wr_nmi;

   assign wr_src  = reg_we_i && (reg_addr_i == SEL_SRC_STAT);
   assign wr_nmi  = reg_we_i && (reg_addr_i == SEL_NMI_STAT);
   assign src_clr = wr_src ? reg_wdata_i[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_en_q  <= '0;
         wake_en_q <= '0;
         rise_en_q <= '0;
         fall_en_q <= '0;
         filt_en_q <= '0;
      end else if (reg_we_i) begin
         case (reg_addr_i)
            SEL_IRQ_EN:  irq_en_q  <= reg_wdata_i[NUM_SRC-1:0];
            SEL_WAKE_EN: wake_en_q <= reg_wdata_i[NUM_SRC-1:0];
            SEL_RISE_EN: rise_en_q <= reg_wdata_i[NUM_SRC-1:0];
            SEL_FALL_EN: fall_en_q <= reg_wdata_i[NUM_SRC-1:0];
            SEL_FILT_EN: filt_en_q <= reg_wdata_i[NUM_SRC-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         SEL_NMI_STAT: begin
            reg_rdata_o[NMI_EVT_BIT] = nmi_evt;
            reg_rdata_o[NMI_OVR_BIT] = nmi_ovr;
         end
         SEL_SRC_STAT: reg_rdata_o[NUM_SRC-1:0] = src_flag;
         SEL_IRQ_EN:   reg_rdata_o[NUM_SRC-1:0] = irq_en_q;
         SEL_WAKE_EN:  reg_rdata_o[NUM_SRC-1:0] = wake_en_q;
         SEL_RISE_EN:  reg_rdata_o[NUM_SRC-1:0] = rise_en_q;
         SEL_FALL_EN:  reg_rdata_o[NUM_SRC-1:0] = fall_en_q;
         SEL_FILT_EN:  reg_rdata_o[NUM_SRC-1:0] = filt_en_q;
         default:      reg_rdata_o = '0;
      endcase
   end

   wkup_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i ({nmi_pad_i, pad_i}),
      .sync_o  (sync_all)
   );

   wkup_src_flags #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_i     (sync_all[NUM_SRC-1:0]),
      .rise_en_i (rise_en_q),
      .fall_en_i (fall_en_q),
      .clr_i     (src_clr),
      .flag_o    (src_flag)
   );

   wkup_nmi_unit u_nmi (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_i     (sync_all[NUM_SRC]),
      .clr_evt_i (wr_nmi && reg_wdata_i[NMI_EVT_BIT]),
      .clr_ovr_i (wr_nmi && reg_wdata_i[NMI_OVR_BIT]),
      .evt_o     (nmi_evt),
      .ovr_o     (nmi_ovr),
      .req_o     (nmi_req_o)
   );

   wkup_vec_merge #(.NUM_SRC(NUM_SRC), .GRP_SIZE(GRP_SIZE), .NUM_VEC(NUM_VEC)) u_merge (
      .flag_i    (src_flag),
      .irq_en_i  (irq_en_q),
      .wake_en_i (wake_en_q),
      .vec_o     (irq_vec_o),
      .wake_o    (wake_o)
   );

   // R6
   irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_en_q == '0) |-> (irq_vec_o == '0));
   // R7
   wake_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_en_q == '0) |-> !wake_o);
   // R8
   nmi_req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(nmi_req_o) |-> $past(sync_all[NUM_SRC]));
endmodule

// File: tb/wkup_irq_ctrl_test.sv
module wkup_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] pads = '0;
   logic        nmi = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [2:0]  vec;
   logic        wake;
   logic        nmi_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   wkup_irq_ctrl uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .pad_i       (pads),
      .nmi_pad_i   (nmi),
      .reg_we_i    (we),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_vec_o   (vec),
      .wake_o      (wake),
      .nmi_req_o   (nmi_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pads = '0; nmi = 1'b0; we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   // pad changed at a falling edge; flag visible after third rising edge
   task automatic pad_to(input int idx, input logic v);
      pads[idx] = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic nmi_to(input logic v);
      nmi = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      for (int a = 0; a < 7; a++) begin
         rd(a[2:0], d);
         check("R1 reg zero", d, 32'h0);
      end
      check("R1 outputs low", {29'h0, vec}, {29'h0, 3'b000});
      check("R1 wake/nmi low", {30'h0, wake, nmi_req}, 32'h0);
   endtask

   task automatic t_edges();
      logic [31:0] d;
      do_reset();
      wr(3'd4, 32'h1);
      wr(3'd5, 32'h2);
      rd(3'd4, d); check("R2 rise enable readback", d, 32'h1);
      rd(3'd5, d); check("R2 fall enable readback", d, 32'h2);
      pad_to(0, 1'b1);
      rd(3'd1, d); check("R2 rising edge sets flag", d, 32'h1);
      pad_to(1, 1'b1);
      rd(3'd1, d); check("R3 rising edge ignored when disabled", d, 32'h1);
      pad_to(1, 1'b0);
      rd(3'd1, d); check("R2 falling edge sets flag", d, 32'h3);
      wr(3'd1, 32'h1);
      pad_to(0, 1'b0);
      rd(3'd1, d); check("R3 falling edge ignored when disabled", d, 32'h2);
      // latency: flag not yet visible after two rising edges
      pads[0] = 1'b1;
      repeat (2) @(negedge clk);
      rd(3'd1, d); check("R2 no flag before third edge", d, 32'h2);
      @(negedge clk);
      rd(3'd1, d); check("R2 flag after third edge", d, 32'h3);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      do_reset();
      wr(3'd4, 32'h3);
      pads[0] = 1'b1; pads[1] = 1'b1;
      repeat (3) @(negedge clk);
      wr(3'd1, 32'h0);
      rd(3'd1, d); check("R4 write zero keeps flags", d, 32'h3);
      wr(3'd1, 32'h1);
      rd(3'd1, d); check("R4 write one clears only that bit", d, 32'h2);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      do_reset();
      wr(3'd4, 32'h8);
      wr(3'd5, 32'h8);
      pad_to(3, 1'b1);
      rd(3'd1, d); check("R5 precondition flag set", d, 32'h8);
      pads[3] = 1'b0;
      repeat (2) @(negedge clk);
      addr = 3'd1; wdata = 32'h8; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      rd(3'd1, d); check("R5 event beats clear", d, 32'h8);
      wr(3'd1, 32'h8);
      rd(3'd1, d); check("R5 plain clear afterwards", d, 32'h0);
   endtask

   task automatic t_vectors();
      logic [31:0] d;
      do_reset();
      wr(3'd4, 32'hFFFFF);
      wr(3'd2, (32'h1 << 7) | (32'h1 << 8) | (32'h1 << 19));
      pad_to(6, 1'b1);
      rd(3'd1, d); check("R6 unmasked source flag set", d, 32'h40);
      check("R6 disabled source gives no vector", {29'h0, vec}, 32'h0);
      pad_to(7, 1'b1);
      check("R6 source 7 to vector 0", {29'h0, vec}, 32'h1);
      wr(3'd1, 32'hFFFFF);
      check("R6 vector drops after clear", {29'h0, vec}, 32'h0);
      pad_to(8, 1'b1);
      check("R6 source 8 to vector 1", {29'h0, vec}, 32'h2);
      wr(3'd1, 32'hFFFFF);
      pad_to(19, 1'b1);
      check("R6 source 19 to vector 2", {29'h0, vec}, 32'h4);
   endtask

   task automatic t_wake();
      do_reset();
      wr(3'd4, 32'hFFFFF);
      wr(3'd3, 32'h20);
      pad_to(4, 1'b1);
      check("R7 wake ignores unenabled flag", {31'h0, wake}, 32'h0);
      pad_to(5, 1'b1);
      check("R7 wake on enabled flag", {31'h0, wake}, 32'h1);
      check("R7 wake does not drive vectors", {29'h0, vec}, 32'h0);
      wr(3'd1, 32'h20);
      check("R7 wake drops after clear", {31'h0, wake}, 32'h0);
   endtask

   task automatic t_nmi();
      logic [31:0] d;
      do_reset();
      nmi_to(1'b1);
      rd(3'd0, d); check("R8 nmi event flag", d, 32'h1);
      check("R8 nmi request high", {31'h0, nmi_req}, 32'h1);
      nmi_to(1'b0);
      rd(3'd0, d); check("R8 falling nmi no change", d, 32'h1);
      nmi_to(1'b1);
      rd(3'd0, d); check("R9 overrun on second event", d, 32'h3);
      wr(3'd0, 32'h0);
      rd(3'd0, d); check("R10 write zero keeps nmi flags", d, 32'h3);
      wr(3'd0, 32'h1);
      rd(3'd0, d); check("R10 event cleared, overrun kept", d, 32'h2);
      check("R10 request held by overrun", {31'h0, nmi_req}, 32'h1);
      wr(3'd0, 32'h2);
      rd(3'd0, d); check("R10 overrun cleared", d, 32'h0);
      check("R10 request released", {31'h0, nmi_req}, 32'h0);
   endtask

   task automatic t_filter();
      logic [31:0] d;
      do_reset();
      wr(3'd6, 32'hFFFFFFFF);
      rd(3'd6, d); check("R11 filter readback", d, 32'h000FFFFF);
      check("R11 filter drives nothing", {28'h0, vec, wake}, 32'h0);
      wr(3'd4, 32'h1);
      pad_to(0, 1'b1);
      rd(3'd1, d); check("R11 edge timing unchanged", d, 32'h1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      t_reset();
      t_edges();
      t_clear();
      t_collide();
      t_vectors();
      t_wake();
      t_nmi();
      t_filter();
      finish_run();
   end
endmodule